// File: doc/BRIEF.md
# Byte-Framed Serial Control Slave

This block is the serial slave that a microcontroller uses to reach a register file. The master lowers chip select for each byte on its own, gives exactly eight clock pulses and raises chip select again. The first byte of an instruction carries a read/write flag and a 7-bit identifier. A number of data bytes follows, and that number depends on the identifier. Write data goes out through a one-cycle write strobe. Read data is fetched from the register file when the data byte's chip select falls, and it is shifted out on a data line that has its own output enable, so that input and output can share one wire.

The serial clock is not related to the system clock and may be gated. All three serial inputs are oversampled through synchronizers, and edges are detected in the system clock domain. The block checks every byte for framing and every identifier for legality. It limits the idle gap while it waits for a data byte. A fault traps the block in an error state and raises a sticky interrupt. The block leaves that state only on a realign byte. Two identifiers are served inside the block: a sync-check register and the interrupt register.

Top module: `sci_slave`

## Requirements
- R1: The first byte of an instruction is received MSB first, with `sdi` sampled on rising `sclk`. Bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the identifier.
- R2: Identifiers 0x00–0x3F take one data byte. Identifiers 0x40–0x4F take two data bytes, and the first of the two has `reg_idx` = 0 (least significant). Each written data byte gives one single-cycle `reg_we` with `reg_addr` = identifier, `reg_idx` = byte index and `reg_wdata` = the byte.
- R3: `sdo_oe` is high only while chip select is low during a data byte of a read instruction, never during a first byte. `sdo` gives the read byte MSB first: the first bit is valid from the chip-select fall, and the bit advances on each falling `sclk`.
- R4: A chip-select-low window with a number of `sclk` pulses other than 8 puts the block in the error state. That byte causes no write.
- R5: An illegal first byte enters the error state. Illegal first bytes are any identifier in 0x50–0x6F or 0x72–0x7E, a write to 0x70 or 0x71, and a read of 0x7F.
- R6: In the error state every byte is ignored (no `reg_we`, `sdo_oe` low) until a well-framed byte 0x7F arrives, which returns the block to idle. When the block is idle, 0x7F as a first byte does nothing. A master that has lost alignment therefore repeats 0x7F until its bytes are taken as first bytes again.
- R7: While a data byte is awaited, a gap of up to `to_limit` system clocks from chip-select rise to the next chip-select fall is accepted. A gap of `to_limit`+1 discards the instruction and enters the error state. `to_limit` = 0 disables the limit.
- R8: A read of identifier 0x70 returns 0x5A.
- R9: `err_irq` rises on entry to the error state and stays high until a read of identifier 0x71. That read returns 0x01 while the flag is set (bit 0 = flag, other bits 0) and then clears the flag.
- R10: After reset the block is idle with `err_irq` = 0, `sdo_oe` = 0 and `reg_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low for one byte |
| sclk | input | 1 | Serial clock, asynchronous, may be gated |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| to_limit | input | TO_W (16) | Inter-byte gap limit in clocks, 0 = off |
| reg_addr | output | 7 | Register identifier |
| reg_idx | output | IDX_W (1) | Byte index within a wide register |
| reg_wdata | output | 8 | Write data byte |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_rdata | input | 8 | Read data for reg_addr/reg_idx |
| err_irq | output | 1 | Sticky error interrupt |

## Verification
Two events can fall in the same system clock: the gap-limit expiry and the chip-select fall of the awaited data byte. The rule is that arrival wins. The bench drives both chip-select edges on the same clock phase. Because both edges pass through identical synchronizers, the gap seen inside the block equals the gap that was driven. The bench sets a limit of 20 and sends one gap of exactly 20 clocks, which must yield a write. It then sends a gap of 21 clocks, which must raise the interrupt and produce no write strobe.

// File: rtl/sci_pkg.sv
package sci_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_ERR  = 2'd2
   } sci_state_t;

   localparam int          BYTE_W     = 8;
   localparam int          ID_W       = 7;
   localparam logic [6:0]  SYNC_ID    = 7'h70;
   localparam logic [6:0]  IRQ_ID     = 7'h71;
   localparam logic [6:0]  REALIGN_ID = 7'h7F;
   localparam logic [7:0]  SYNC_VAL   = 8'h5A;
   localparam logic [7:0]  REALIGN_BYTE = {1'b0, REALIGN_ID};
endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad
         $error("sci_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sci_shift.sv
module sci_shift #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(2 * BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bit_rise,
   input  logic              bit_fall,
   input  logic              din,
   input  logic [BYTE_W-1:0] load_val,
   output logic [BYTE_W-1:0] rx_byte,
   output logic [CNT_W-1:0]  bit_cnt,
   output logic              dout
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   logic [BYTE_W-1:0] tx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte <= '0;
         bit_cnt <= '0;
         tx_q    <= '0;
      end else if (start) begin
         bit_cnt <= '0;
         tx_q    <= load_val;
      end else begin
         if (bit_rise) begin
            rx_byte <= {rx_byte[BYTE_W-2:0], din};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
         end
         if (bit_fall) tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
      end
   end

   assign dout = tx_q[BYTE_W-1];
endmodule

// File: rtl/sci_ctrl.sv
module sci_ctrl
   import sci_pkg::*;
#(
   parameter int NARROW_COUNT = 64,
   parameter int WIDE_BASE    = 64,
   parameter int WIDE_COUNT   = 16,
   parameter int WIDE_BYTES   = 2,
   parameter int TO_W         = 16,
   parameter int CNT_W        = 4,
   localparam int IDX_W       = $clog2(WIDE_BYTES),
   localparam int LEN_W       = $clog2(WIDE_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              cs_fall,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic [TO_W-1:0]   to_limit,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic [BYTE_W-1:0] load_val,
   output logic              sdo_oe,
   output logic [ID_W-1:0]   reg_addr,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   output logic              err_irq,
   output sci_state_t        st
);
   sci_state_t        st_d;
   logic [ID_W-1:0]   cur_id;
   logic              cur_rw;
   logic [LEN_W-1:0]  rem;
   logic [IDX_W-1:0]  idx;
   logic [TO_W-1:0]   to_cnt;
   logic              frame_ok, expire, enter_err, accept_cmd, irq_rd;
   logic [LEN_W-1:0]  cmd_len;

   function automatic logic [LEN_W-1:0] len_of(input logic rw, input logic [ID_W-1:0] id);
      int n;
      n = int'(id);
      if (n < NARROW_COUNT)                                  return LEN_W'(1);
      if (n >= WIDE_BASE && n < WIDE_BASE + WIDE_COUNT)      return LEN_W'(WIDE_BYTES);
      if (rw && (id == SYNC_ID || id == IRQ_ID))             return LEN_W'(1);
      return '0;
   endfunction

   assign frame_ok = (bit_cnt == CNT_W'(BYTE_W));
   assign cmd_len  = len_of(rx_byte[BYTE_W-1], rx_byte[ID_W-1:0]);
   assign expire   = (st == ST_DATA) && !cs_act && !byte_done &&
                     (to_limit != '0) && (to_cnt == to_limit - 1'b1);

   always_comb begin
      st_d       = st;
      accept_cmd = 1'b0;
      case (st)
         ST_IDLE: if (byte_done) begin
            if (!frame_ok)                      st_d = ST_ERR;
            else if (rx_byte == REALIGN_BYTE)   st_d = ST_IDLE;
            else if (cmd_len == '0)             st_d = ST_ERR;
            else begin
               st_d       = ST_DATA;
               accept_cmd = 1'b1;
            end
         end
         ST_DATA: begin
            if (byte_done) begin
               if (!frame_ok)                   st_d = ST_ERR;
               else if (rem == LEN_W'(1))       st_d = ST_IDLE;
            end else if (expire)                st_d = ST_ERR;
         end
         ST_ERR: if (byte_done && frame_ok && rx_byte == REALIGN_BYTE) st_d = ST_IDLE;
         default: st_d = ST_ERR;
      endcase
   end

   assign enter_err = (st_d == ST_ERR) && (st != ST_ERR);
   assign irq_rd    = cs_fall && (st == ST_DATA) && cur_rw && (cur_id == IRQ_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_id  <= '0;
         cur_rw  <= 1'b0;
         rem     <= '0;
         idx     <= '0;
         to_cnt  <= '0;
         err_irq <= 1'b0;
      end else begin
         st <= st_d;
         if (accept_cmd) begin
            cur_id <= rx_byte[ID_W-1:0];
            cur_rw <= rx_byte[BYTE_W-1];
            rem    <= cmd_len;
            idx    <= '0;
            to_cnt <= '0;
         end else if (st == ST_DATA) begin
            if (byte_done) begin
               rem    <= rem - 1'b1;
               idx    <= idx + 1'b1;
               to_cnt <= '0;
            end else if (!cs_act && !expire) begin
               to_cnt <= to_cnt + 1'b1;
            end
         end
         if (enter_err)   err_irq <= 1'b1;
         else if (irq_rd) err_irq <= 1'b0;
      end
   end

   always_comb begin
      if (cur_id == SYNC_ID)     load_val = SYNC_VAL;
      else if (cur_id == IRQ_ID) load_val = {{(BYTE_W-1){1'b0}}, err_irq};
      else                       load_val = reg_rdata;
   end

   assign sdo_oe    = (st == ST_DATA) && cur_rw && cs_act;
   assign reg_we    = (st == ST_DATA) && byte_done && frame_ok && !cur_rw;
   assign reg_addr  = cur_id;
   assign reg_idx   = idx;
   assign reg_wdata = rx_byte;
endmodule

// File: rtl/sci_slave.sv
module sci_slave
   import sci_pkg::*;
#(
   parameter int NARROW_COUNT = 64,
   parameter int WIDE_BASE    = 64,
   parameter int WIDE_COUNT   = 16,
   parameter int WIDE_BYTES   = 2,
   parameter int TO_W         = 16,
   parameter int SYNC_STAGES  = 2,
   localparam int IDX_W       = $clog2(WIDE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe,
   input  logic [TO_W-1:0]   to_limit,
   output logic [6:0]        reg_addr,
   output logic [IDX_W-1:0]  reg_idx,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata,
   output logic              err_irq
);
   localparam int CNT_W = $clog2(2 * BYTE_W);

   generate
      if (NARROW_COUNT > WIDE_BASE) begin : g_chk_map
         $error("narrow range overlaps wide range");
      end
      if (WIDE_BASE + WIDE_COUNT > int'(SYNC_ID)) begin : g_chk_top
         $error("wide range reaches internal identifiers");
      end
      if (WIDE_BYTES < 2 || WIDE_BYTES > 4) begin : g_chk_wide
         $error("WIDE_BYTES must be 2 to 4");
      end
   endgenerate

   logic [2:0]  raw_in, syn_in;
   logic        cs_act, cs_act_d, sclk_s, sclk_d, sdi_s;
   logic        cs_fall, byte_done, bit_rise, bit_fall;
   logic [7:0]  rx_byte, load_val;
   logic [CNT_W-1:0] bit_cnt;
   sci_state_t  st_w;

   assign raw_in = {cs_n, sclk, sdi};

   sci_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign cs_act = !syn_in[2];
   assign sclk_s = syn_in[1];
   assign sdi_s  = syn_in[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_act_d <= 1'b0;
         sclk_d   <= 1'b0;
      end else begin
         cs_act_d <= cs_act;
         sclk_d   <= sclk_s;
      end
   end

   assign cs_fall   = cs_act && !cs_act_d;
   assign byte_done = !cs_act && cs_act_d;
   assign bit_rise  = cs_act && sclk_s && !sclk_d;
   assign bit_fall  = cs_act && !sclk_s && sclk_d;

   sci_shift #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(cs_fall), .bit_rise(bit_rise),
      .bit_fall(bit_fall), .din(sdi_s), .load_val(load_val),
      .rx_byte(rx_byte), .bit_cnt(bit_cnt), .dout(sdo)
   );

   sci_ctrl #(
      .NARROW_COUNT(NARROW_COUNT), .WIDE_BASE(WIDE_BASE), .WIDE_COUNT(WIDE_COUNT),
      .WIDE_BYTES(WIDE_BYTES), .TO_W(TO_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
      .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt),
      .to_limit(to_limit), .reg_rdata(reg_rdata), .load_val(load_val),
      .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .err_irq(err_irq), .st(st_w)
   );
endmodule

// File: rtl/sci_slave_chk.sv
module sci_slave_chk
   import sci_pkg::*;
#(
   parameter int NARROW_COUNT = 64,
   parameter int WIDE_BASE    = 64,
   parameter int WIDE_COUNT   = 16
) (
   input logic       clk,
   input logic       rst_n,
   input sci_state_t st,
   input logic       sdo_oe,
   input logic       reg_we,
   input logic [6:0] reg_addr,
   input logic       err_irq
);
   // R3: output enable only while a data byte of an instruction is in flight
   a_r3_oe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_oe |-> (st == ST_DATA));

   // R6: error state is silent
   a_r6_quiet_in_err: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERR) |-> (!reg_we && !sdo_oe));

   // R9: entering the error state raises the interrupt
   a_r9_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ERR && $past(st) != ST_ERR) |-> err_irq);

   // R2: write strobe lasts one cycle
   a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R2, R5: strobes only reach mapped identifiers
   a_r5_we_legal: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (int'(reg_addr) < NARROW_COUNT ||
                  (int'(reg_addr) >= WIDE_BASE && int'(reg_addr) < WIDE_BASE + WIDE_COUNT)));
endmodule

bind sci_slave sci_slave_chk #(
   .NARROW_COUNT(NARROW_COUNT), .WIDE_BASE(WIDE_BASE), .WIDE_COUNT(WIDE_COUNT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st_w), .sdo_oe(sdo_oe), .reg_we(reg_we),
   .reg_addr(reg_addr), .err_irq(err_irq)
);

// File: tb/tb_sci_slave.sv
module tb_sci_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic        sdo, sdo_oe, reg_we, err_irq;
   logic [15:0] to_limit = 16'd0;
   logic [6:0]  reg_addr;
   logic [0:0]  reg_idx;
   logic [7:0]  reg_wdata, reg_rdata;

   int checks = 0, failures = 0, we_cnt = 0;
   logic [6:0] w_addr [2];
   logic [7:0] w_data [2];
   bit finished = 0;

   always #10 clk = ~clk;

   sci_slave dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .to_limit(to_limit), .reg_addr(reg_addr),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata), .err_irq(err_irq)
   );

   function automatic logic [7:0] model_rd(input logic [6:0] a, input logic i);
      return {i, a} ^ 8'h96;
   endfunction
   assign reg_rdata = model_rd(reg_addr, reg_idx[0]);

   always @(negedge clk) if (reg_we) begin
      w_addr[reg_idx[0]] <= reg_addr;
      w_data[reg_idx[0]] <= reg_wdata;
      we_cnt <= we_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, input int pulses,
                       output logic [7:0] rx, output bit oe_seen);
      rx = '0; oe_seen = 0;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < pulses; i++) begin
         sdi = (i < 8) ? tx[7-i] : 1'b0;
         repeat (2) @(negedge clk);
         sclk = 1'b1;
         rx = {rx[6:0], sdo};
         if (sdo_oe) oe_seen = 1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic gap(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      logic [7:0] r; bit o;
      xfer(b, 8, r, o); gap(10);
   endtask

   task automatic get(input logic [7:0] cmd, output logic [7:0] r, output bit o);
      logic [7:0] d; bit oc;
      xfer(cmd, 8, d, oc); gap(10);
      xfer(8'h00, 8, r, o); gap(10);
      chk(!oc, "R3 oe during first byte", oc, 0);
   endtask

   task automatic clear_err();
      logic [7:0] r; bit o;
      put(8'h7F);
      get(8'hF1, r, o);
   endtask

   task automatic t_reset();
      chk(err_irq == 0, "R10 irq after reset", err_irq, 0);
      chk(sdo_oe == 0, "R10 oe after reset", sdo_oe, 0);
      chk(reg_we == 0, "R10 we after reset", reg_we, 0);
   endtask

   task automatic t_write_narrow();
      int c = we_cnt;
      put(8'h05); put(8'hA3);
      chk(we_cnt == c + 1, "R1 one write", we_cnt - c, 1);
      chk(w_addr[0] == 7'h05 && w_data[0] == 8'hA3, "R2 narrow write", {w_addr[0], w_data[0]}, 16'h05A3);
   endtask

   task automatic t_write_wide();
      int c = we_cnt;
      put(8'h42); put(8'h34); put(8'h12);
      chk(we_cnt == c + 2, "R2 wide write count", we_cnt - c, 2);
      chk(w_data[0] == 8'h34 && w_data[1] == 8'h12, "R2 wide order", {w_data[1], w_data[0]}, 16'h1234);
   endtask

   task automatic t_reads();
      logic [7:0] r, d; bit o, oc;
      get(8'h8C, r, o);
      chk(r == model_rd(7'h0C, 1'b0), "R3 narrow read", r, model_rd(7'h0C, 1'b0));
      chk(o, "R3 oe in read data", o, 1);
      xfer(8'hC5, 8, d, oc); gap(10);
      xfer(8'h00, 8, r, o); gap(10);
      chk(r == model_rd(7'h45, 1'b0), "R2 wide read lsb", r, model_rd(7'h45, 1'b0));
      xfer(8'h00, 8, r, o); gap(10);
      chk(r == model_rd(7'h45, 1'b1), "R2 wide read msb", r, model_rd(7'h45, 1'b1));
      get(8'hF0, r, o);
      chk(r == 8'h5A, "R8 sync value", r, 8'h5A);
      chk(err_irq == 0, "R9 irq quiet after good traffic", err_irq, 0);
   endtask

   task automatic t_framing(input int pulses);
      logic [7:0] r; bit o; int c;
      xfer(8'h05, pulses, r, o); gap(10);
      chk(err_irq == 1, "R4 framing error", err_irq, 1);
      c = we_cnt;
      put(8'h06); put(8'h11);
      chk(we_cnt == c, "R6 write ignored in error", we_cnt - c, 0);
      xfer(8'h8C, 8, r, o); gap(10);
      xfer(8'h00, 8, r, o); gap(10);
      chk(!o, "R6 no output in error", o, 0);
      put(8'h7F);
      get(8'hF1, r, o);
      chk(r == 8'h01, "R9 irq read set", r, 1);
      get(8'hF1, r, o);
      chk(r == 8'h00 && err_irq == 0, "R9 irq cleared", r, 0);
   endtask

   task automatic t_illegal();
      logic [7:0] r; bit o;
      put(8'h60);
      chk(err_irq == 1, "R5 illegal id", err_irq, 1);
      clear_err();
      put(8'h70);
      chk(err_irq == 1, "R5 write to sync", err_irq, 1);
      clear_err();
      put(8'hFF);
      chk(err_irq == 1, "R5 read of realign", err_irq, 1);
      clear_err();
      chk(err_irq == 0, "R9 cleared after illegal", err_irq, 0);
   endtask

   task automatic t_timeout();
      logic [7:0] r; bit o; int c;
      to_limit = 16'd20;
      c = we_cnt;
      xfer(8'h07, 8, r, o); gap(20);
      xfer(8'h99, 8, r, o); gap(10);
      chk(we_cnt == c + 1 && err_irq == 0, "R7 gap at limit accepted", we_cnt - c, 1);
      c = we_cnt;
      xfer(8'h07, 8, r, o); gap(21);
      xfer(8'h98, 8, r, o); gap(10);
      chk(we_cnt == c && err_irq == 1, "R7 gap over limit rejected", we_cnt - c, 0);
      clear_err();
      to_limit = 16'd0;
      c = we_cnt;
      xfer(8'h08, 8, r, o); gap(300);
      xfer(8'h55, 8, r, o); gap(10);
      chk(we_cnt == c + 1 && err_irq == 0, "R7 limit disabled", we_cnt - c, 1);
   endtask

   task automatic t_resync();
      logic [7:0] r; bit o; int c;
      c = we_cnt;
      put(8'h42); put(8'h7F); put(8'h7F); put(8'h7F);
      chk(we_cnt == c + 2, "R6 realign consumed as data", we_cnt - c, 2);
      get(8'hF0, r, o);
      chk(r == 8'h5A && err_irq == 0, "R6 aligned after repeats", r, 8'h5A);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      gap(5);
      t_write_narrow();
      t_write_wide();
      t_reads();
      t_framing(7);
      t_framing(9);
      t_illegal();
      t_timeout();
      t_resync();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule